// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column-burst engine of a synchronous DRAM device model. It holds the operating-mode word, written by a mode-load command, and decodes from it the read latency, the burst ordering (linear or interleaved) and the burst length. Every read or write command starts a burst. The block then produces one column address per enabled clock. For reads it also produces a data-valid strobe that lags the column beats by the programmed latency.

Per-lane data masks are applied differently on the two paths. A mask takes the read output drive away two enabled clocks after it is sampled. On the write path it blocks the write strobe in the same cycle. A burst ends when its length is used up, when a stop command arrives, or when a new read or write replaces it on any clock. A full-page burst runs and wraps until it is stopped or replaced. An auto-precharge request taken with the command is flagged on the last beat of a burst that completes.

When the clock enable is low, every register holds its value for that cycle. The memory array, refresh and pad behaviour are outside the block.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, col_valid, rd_valid, ap_fire and mode_err are 0, cfg_cl is 2, cfg_ilv is 0 and cfg_blc is 0.
- R2: A mode-load command (cmd = 3'b001) with bank = 0, taken while no burst runs and outside the wait window, loads the latency from addr[6:4] (1, 2 or 3), the ordering from addr[3] (0 linear, 1 interleaved) and the length code from addr[2:0] (0:1, 1:2, 2:4, 3:8, 7:full page). The new values appear on cfg_cl, cfg_ilv and cfg_blc after that edge. A mode-load with bank other than 0 changes nothing.
- R3: A mode-load with an addr[6:4] code other than 1..3, or with a length code other than 0..3 and 7, or with code 7 together with interleaved ordering, sets mode_err and leaves the configuration unchanged. A later valid mode-load clears mode_err.
- R4: For the 2 enabled edges after an accepted mode-load, every command is ignored.
- R5: A read (cmd = 3'b010) or write (cmd = 3'b011) sampled at edge T with start column addr[8:0] gives col_valid = 1 and, after edge T+k, col_addr = (start with its low log2(BL) bits replaced by (start+k) mod BL) in linear order, for k = 0..BL-1. beat_wr is 1 for writes.
- R6: In interleaved order the column after edge T+k is start XOR k.
- R7: A full-page burst steps the column by one modulo 512 on every enabled edge and does not end by itself.
- R8: A stop command (cmd = 3'b100) ends the running burst at that edge.
- R9: A read or write during a burst replaces it at that edge, with beat 0 of the new burst after that edge.
- R10: rd_valid is high in the cycle after edge T+CL-1+k for each read beat k, where CL is the latency; write beats never raise it.
- R11: A mask bit dmask[l] sampled at enabled edge t drops rd_drive[l] in the cycle after enabled edge t+2; otherwise rd_drive[l] equals rd_valid.
- R12: wr_en[l] is high exactly in cycles with an active write beat, cke high and dmask[l] low.
- R13: addr[10] sampled with a read or write makes ap_fire high during the last beat of that burst when it completes by length; stopped, replaced or full-page bursts never raise it.
- R14: With cke low at an edge, the column state, the latency and mask pipelines, the configuration and the wait window all hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes all state |
| cmd | input | 3 | Command code: 0 idle, 1 mode-load, 2 read, 3 write, 4 stop |
| bank | input | 2 | Bank select; must be 0 for a mode-load |
| addr | input | 12 | Mode word, or start column [8:0] plus auto-precharge bit [10] |
| dmask | input | 2 | Per-lane data mask |
| col_valid | output | 1 | A burst beat is active |
| col_addr | output | 9 | Column of the current beat |
| beat_wr | output | 1 | Current beat belongs to a write |
| ap_fire | output | 1 | Last beat of a completing auto-precharge burst |
| rd_valid | output | 1 | Read data due, delayed by the latency |
| rd_drive | output | 2 | Per-lane read output drive, after mask |
| wr_en | output | 2 | Per-lane write strobe, after mask |
| cfg_cl | output | 2 | Current read latency |
| cfg_ilv | output | 1 | Current interleaved-order flag |
| cfg_blc | output | 3 | Current burst length code |
| mode_err | output | 1 | Last mode-load carried a reserved code |

## Verification
Configuration and mode_err are due one cycle after the mode-load edge. Beat k of a burst is due in the cycle after edge T+k, rd_valid for that beat CL-1 cycles later, a read mask effect three cycles after the mask is driven, and wr_en in the same cycle as the mask. The bench drives inputs just after the falling edge and advances a behavioural model on the rising edge. It compares every output against that model at the next falling edge, so each result is checked in the exact cycle it is due. Frozen edges (cke low) are excluded from every count in both model and design.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE = 3'd0,
      CMD_MODE = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_STOP = 3'd4
   } sbs_cmd_e;

   typedef struct packed {
      logic [1:0] cl;
      logic       ilv;
      logic [2:0] blc;
   } sbs_cfg_t;

   localparam logic [2:0] BLC_FULL = 3'd7;

   // A mode word is usable when latency is 1..3 and the length code is
   // 1/2/4/8 beats, or full page under linear ordering only.
   function automatic logic mode_word_ok(input logic [6:0] op);
      logic cl_ok;
      logic bl_ok;
      cl_ok = (op[6:4] == 3'd1) || (op[6:4] == 3'd2) || (op[6:4] == 3'd3);
      bl_ok = (op[2:0] <= 3'd3) || ((op[2:0] == BLC_FULL) && !op[3]);
      return cl_ok && bl_ok;
   endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
   import sbs_pkg::*;
#(
   parameter int BANK_W  = 2,
   parameter int MRD_CYC = 2,
   parameter int RST_CL  = 2,
   parameter int RST_BLC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  sbs_cmd_e          cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [6:0]        op,
   input  logic              burst_act,
   output sbs_cfg_t          cfg,
   output logic              mode_err,
   output logic              busy
);

   localparam int CNT_W = $clog2(MRD_CYC + 1);

   initial begin
      if (MRD_CYC < 1) $fatal(1, "MRD_CYC must be at least 1");
      if (RST_CL < 1 || RST_CL > 3) $fatal(1, "RST_CL out of range");
      if (RST_BLC > 3) $fatal(1, "RST_BLC must be a fixed length code");
   end

   logic [CNT_W-1:0] wait_cnt;
   logic             load_hit;

   assign busy     = (wait_cnt != '0);
   assign load_hit = (cmd == CMD_MODE) && (bank == '0) && !busy && !burst_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '{cl: 2'(RST_CL), ilv: 1'b0, blc: 3'(RST_BLC)};
         mode_err <= 1'b0;
         wait_cnt <= '0;
      end else if (cke) begin
         if (load_hit) begin
            wait_cnt <= CNT_W'(MRD_CYC);
            if (mode_word_ok(op)) begin
               cfg      <= '{cl: op[5:4], ilv: op[3], blc: op[2:0]};
               mode_err <= 1'b0;
            end else begin
               mode_err <= 1'b1;
            end
         end else if (busy) begin
            wait_cnt <= wait_cnt - 1'b1;
         end
      end
   end

   // R2: a mode-load aimed at a nonzero bank touches nothing
   a_r2_bank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cmd == CMD_MODE && bank != '0) |=> ($stable(cfg) && $stable(mode_err)));

   // R3: a rejected word leaves the previous settings in place
   a_r3_err_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_err) |-> (cfg == $past(cfg)));

   // R4: nothing reprograms the mode inside the wait window
   a_r4_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cke) |=> $stable(cfg));

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
   import sbs_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  sbs_cmd_e         cmd,
   input  logic [COL_W-1:0] start_col,
   input  logic             ap_req,
   input  logic             ilv,
   input  logic [2:0]       blc,
   input  logic             busy,
   output logic             act,
   output logic [COL_W-1:0] col_addr,
   output logic             beat_wr,
   output logic             ap_fire,
   output logic             rd_beat
);

   initial begin
      if (COL_W < 3) $fatal(1, "COL_W must cover an 8-beat burst");
   end

   logic [COL_W-1:0] start_q;
   logic [COL_W-1:0] idx;
   logic [COL_W-1:0] blmask;
   logic             ap_q;
   logic             full;
   logic             last;
   logic             go;
   logic             stop;

   always_comb begin
      unique case (blc)
         3'd0:    blmask = '0;
         3'd1:    blmask = COL_W'(1);
         3'd2:    blmask = COL_W'(3);
         3'd3:    blmask = COL_W'(7);
         default: blmask = '1;
      endcase
   end

   assign full  = (blc == BLC_FULL);
   assign last  = !full && (idx == blmask);
   assign go    = !busy && ((cmd == CMD_RD) || (cmd == CMD_WR));
   assign stop  = !busy && (cmd == CMD_STOP);

   // One mask covers all three orders: interleave flips low bits,
   // linear wraps them, full page wraps the whole column.
   assign col_addr = ilv ? (start_q ^ idx)
                         : ((start_q & ~blmask) | ((start_q + idx) & blmask));

   assign ap_fire = act && ap_q && last;
   assign rd_beat = act && !beat_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         start_q <= '0;
         idx     <= '0;
         beat_wr <= 1'b0;
         ap_q    <= 1'b0;
      end else if (cke) begin
         if (go) begin
            act     <= 1'b1;
            idx     <= '0;
            start_q <= start_col;
            beat_wr <= (cmd == CMD_WR);
            ap_q    <= ap_req;
         end else if (stop) begin
            act  <= 1'b0;
            ap_q <= 1'b0;
         end else if (act) begin
            if (last) act <= 1'b0;
            else      idx <= idx + 1'b1;
         end
      end
   end

   // R5: a fixed-length beat index never leaves its length window
   a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !full) |-> ((idx & ~blmask) == '0));

   // R8: stop ends the burst on its edge
   a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && stop) |=> !act);

   // R9: a new column command restarts at beat zero
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && go) |=> (act && idx == '0));

   // R13: the flagged beat is the final one
   a_r13_ap_last: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && ap_fire && !go) |=> !act);

   // R14: frozen edge keeps column state
   a_r14_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(col_addr) && $stable(act) && $stable(idx)));

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
   parameter int LANES    = 2,
   parameter int MASK_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic [1:0]       cl,
   input  logic             rd_beat,
   input  logic [LANES-1:0] dmask,
   output logic             rd_valid,
   output logic [LANES-1:0] rd_drive
);

   localparam int MAX_CL = 3;

   initial begin
      if (LANES < 1) $fatal(1, "LANES must be at least 1");
      if (MASK_LAT < 1) $fatal(1, "MASK_LAT must be at least 1");
   end

   logic [MAX_CL-1:1] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg <= '0;
      else if (cke) stg <= {stg[MAX_CL-2:1], rd_beat};
   end

   always_comb begin
      unique case (cl)
         2'd2:    rd_valid = stg[1];
         2'd3:    rd_valid = stg[2];
         default: rd_valid = rd_beat;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [MASK_LAT:0] mch;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   mch <= '0;
         else if (cke) mch <= {mch[MASK_LAT-1:0], dmask[g]};
      end

      assign rd_drive[g] = rd_valid && !mch[MASK_LAT];

      if (MASK_LAT == 2) begin : g_chk
         // R11: a mask three unfrozen edges back silences the lane
         a_r11_mask_late: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 3) && $past(cke) && $past(cke, 2) && $past(cke, 3)
             && $past(dmask[g], 3)) |-> !rd_drive[g]);
      end
   end

   // R10: at latency 2 the strobe trails the read beat by one edge
   a_r10_cl2_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cke) && cl == 2'd2 && $past(cl) == 2'd2) |-> (rd_valid == $past(rd_beat)));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
   import sbs_pkg::*;
#(
   parameter int COL_W    = 9,
   parameter int ADDR_W   = 12,
   parameter int BANK_W   = 2,
   parameter int LANES    = 2,
   parameter int MASK_LAT = 2,
   parameter int MRD_CYC  = 2,
   parameter int RST_CL   = 2,
   parameter int RST_BLC  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic [2:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  dmask,
   output logic              col_valid,
   output logic [COL_W-1:0]  col_addr,
   output logic              beat_wr,
   output logic              ap_fire,
   output logic              rd_valid,
   output logic [LANES-1:0]  rd_drive,
   output logic [LANES-1:0]  wr_en,
   output logic [1:0]        cfg_cl,
   output logic              cfg_ilv,
   output logic [2:0]        cfg_blc,
   output logic              mode_err
);

   localparam int AP_BIT = 10;

   initial begin
      if (ADDR_W <= AP_BIT) $fatal(1, "ADDR_W must reach the precharge bit");
      if (COL_W > AP_BIT) $fatal(1, "column field overlaps the precharge bit");
   end

   sbs_cmd_e cmd_e;
   sbs_cfg_t cfg;
   logic     busy;
   logic     rd_beat;
   logic     unused_addr;

   assign cmd_e       = sbs_cmd_e'(cmd);
   assign unused_addr = ^addr;

   sbs_mode_reg #(
      .BANK_W (BANK_W),
      .MRD_CYC(MRD_CYC),
      .RST_CL (RST_CL),
      .RST_BLC(RST_BLC)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .cmd      (cmd_e),
      .bank     (bank),
      .op       (addr[6:0]),
      .burst_act(col_valid),
      .cfg      (cfg),
      .mode_err (mode_err),
      .busy     (busy)
   );

   sbs_col_gen #(
      .COL_W(COL_W)
   ) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .cmd      (cmd_e),
      .start_col(addr[COL_W-1:0]),
      .ap_req   (addr[AP_BIT]),
      .ilv      (cfg.ilv),
      .blc      (cfg.blc),
      .busy     (busy),
      .act      (col_valid),
      .col_addr (col_addr),
      .beat_wr  (beat_wr),
      .ap_fire  (ap_fire),
      .rd_beat  (rd_beat)
   );

   sbs_rd_pipe #(
      .LANES   (LANES),
      .MASK_LAT(MASK_LAT)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke     (cke),
      .cl      (cfg.cl),
      .rd_beat (rd_beat),
      .dmask   (dmask),
      .rd_valid(rd_valid),
      .rd_drive(rd_drive)
   );

   // Write masking acts with no delay on the beat it covers.
   for (genvar g = 0; g < LANES; g++) begin : g_wr
      assign wr_en[g] = col_valid && beat_wr && cke && !dmask[g];
   end

   assign cfg_cl  = cfg.cl;
   assign cfg_ilv = cfg.ilv;
   assign cfg_blc = cfg.blc;

   // R12: write strobes only ride on live, unfrozen write beats
   a_r12_wr_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en) |-> (col_valid && beat_wr && cke));

endmodule

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;

   localparam int LN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke = 1'b1;
   logic [2:0]    cmd = 3'd0;
   logic [1:0]    bank = 2'd0;
   logic [11:0]   addr = '0;
   logic [LN-1:0] dmask = '0;
   logic          col_valid, beat_wr, ap_fire, rd_valid, cfg_ilv, mode_err;
   logic [8:0]    col_addr;
   logic [LN-1:0] rd_drive, wr_en;
   logic [1:0]    cfg_cl;
   logic [2:0]    cfg_blc;

   always #2 clk = ~clk;

   sdram_burst_seq dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .addr(addr),
      .dmask(dmask), .col_valid(col_valid), .col_addr(col_addr), .beat_wr(beat_wr),
      .ap_fire(ap_fire), .rd_valid(rd_valid), .rd_drive(rd_drive), .wr_en(wr_en),
      .cfg_cl(cfg_cl), .cfg_ilv(cfg_ilv), .cfg_blc(cfg_blc), .mode_err(mode_err)
   );

   int    n_chk = 0;
   int    n_err = 0;
   bit    cmp_en = 0;
   bit    done = 0;
   string phase = "R1 reset";

   // behavioural reference state
   int m_cl, m_ilv, m_blc, m_err, m_mrd, m_act, m_start, m_k, m_wr, m_ap;
   int hr1, hr2;
   int mq [LN][3];

   function automatic int blen(int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         default: return 512;
      endcase
   endfunction

   function automatic int exp_col();
      int b;
      b = blen(m_blc);
      if (m_ilv != 0) return m_start ^ m_k;
      if (m_blc == 7) return (m_start + m_k) % 512;
      return (m_start / b) * b + ((m_start % b) + m_k) % b;
   endfunction

   function automatic bit word_ok(int w);
      int c, t, l;
      c = (w >> 4) & 7; t = (w >> 3) & 1; l = w & 7;
      return (c >= 1 && c <= 3) && (l <= 3 || (l == 7 && t == 0));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cl = 2; m_ilv = 0; m_blc = 0; m_err = 0; m_mrd = 0;
         m_act = 0; m_start = 0; m_k = 0; m_wr = 0; m_ap = 0;
         hr1 = 0; hr2 = 0;
         for (int l = 0; l < LN; l++) for (int j = 0; j < 3; j++) mq[l][j] = 0;
      end else if (cke) begin
         int was_act, busy, rdb;
         rdb = (m_act != 0 && m_wr == 0) ? 1 : 0;
         hr2 = hr1; hr1 = rdb;
         for (int l = 0; l < LN; l++) begin
            mq[l][2] = mq[l][1]; mq[l][1] = mq[l][0]; mq[l][0] = dmask[l];
         end
         was_act = m_act;
         busy = (m_mrd > 0) ? 1 : 0;
         if (m_mrd > 0) m_mrd--;
         if (m_act != 0) begin
            if (m_blc != 7 && m_k == blen(m_blc) - 1) m_act = 0;
            else m_k = (m_k + 1) % 512;
         end
         if (busy == 0) begin
            case (cmd)
               3'd2, 3'd3: begin
                  m_act = 1; m_k = 0; m_start = addr % 512;
                  m_wr = (cmd == 3'd3) ? 1 : 0; m_ap = (addr >> 10) & 1;
               end
               3'd4: begin m_act = 0; m_ap = 0; end
               3'd1: if (bank == 0 && was_act == 0) begin
                  m_mrd = 2;
                  if (word_ok(addr)) begin
                     m_cl = (addr >> 4) & 3; m_ilv = (addr >> 3) & 1; m_blc = addr & 7;
                     m_err = 0;
                  end else m_err = 1;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", phase, what, act, exp);
      end
   endtask

   // compare every output against the model each falling edge
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         int e_rdv, rdb_now, e_ap;
         rdb_now = (m_act != 0 && m_wr == 0) ? 1 : 0;
         e_rdv = (m_cl == 1) ? rdb_now : (m_cl == 2) ? hr1 : hr2;
         e_ap = (m_act != 0 && m_ap != 0 && m_blc != 7 && m_k == blen(m_blc) - 1) ? 1 : 0;
         chk("col_valid (R5 R8 R9)", col_valid, m_act);
         if (m_act != 0) begin
            chk("col_addr (R5 R6 R7)", col_addr, exp_col());
            chk("beat_wr (R5)", beat_wr, m_wr);
         end
         chk("rd_valid (R10)", rd_valid, e_rdv);
         chk("ap_fire (R13)", ap_fire, e_ap);
         for (int l = 0; l < LN; l++) begin
            chk($sformatf("rd_drive[%0d] (R11)", l), rd_drive[l],
                (e_rdv != 0 && mq[l][2] == 0) ? 1 : 0);
            chk($sformatf("wr_en[%0d] (R12)", l), wr_en[l],
                (m_act != 0 && m_wr != 0 && cke && !dmask[l]) ? 1 : 0);
         end
         chk("cfg_cl (R2 R3)", cfg_cl, m_cl);
         chk("cfg_ilv (R2 R3)", cfg_ilv, m_ilv);
         chk("cfg_blc (R2 R3)", cfg_blc, m_blc);
         chk("mode_err (R3)", mode_err, m_err);
      end
   end

   task automatic step(input int c, input int b, input int a,
                       input int dm = 0, input bit ck = 1'b1);
      @(negedge clk);
      #1;
      cmd = 3'(c); bank = 2'(b); addr = 12'(a); dmask = LN'(dm); cke = ck;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_err++;
         $display("FAIL watchdog (R1 run did not end) actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      idle(3);
      @(negedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, directed
      chk("R1 col_valid", col_valid, 0);
      chk("R1 rd_valid", rd_valid, 0);
      chk("R1 ap_fire", ap_fire, 0);
      chk("R1 mode_err", mode_err, 0);
      chk("R1 cfg_cl", cfg_cl, 2);
      chk("R1 cfg_blc", cfg_blc, 0);
      cmp_en = 1;

      phase = "R2 mode load"; step(1, 0, 'h22); idle(2);
      phase = "R2 bank select ignored"; step(1, 1, 'h3B); idle(3);
      phase = "R5 R10 linear read"; step(2, 0, 5); idle(8);
      phase = "R11 read mask";
      step(2, 0, 'h40); step(0, 0, 0, 1); step(0, 0, 0, 0); step(0, 0, 0, 2);
      step(0, 0, 0, 3); idle(8);
      phase = "R6 interleave"; step(1, 0, 'h3B); idle(2); step(2, 0, 'h1D); idle(13);
      phase = "R3 reserved latency"; step(1, 0, 'h00); idle(3);
      phase = "R3 reserved full-page interleave"; step(1, 0, 'h1F); idle(3);
      phase = "R3 valid load clears"; step(1, 0, 'h23); idle(3);
      phase = "R4 mode wait";
      step(1, 0, 'h23); step(2, 0, 3); step(3, 0, 4); step(2, 0, 6); idle(12);
      phase = "R12 write mask";
      step(3, 0, 'h100, 0);
      for (int i = 0; i < 9; i++) step(0, 0, 0, i % 4);
      idle(3);
      phase = "R9 interrupt";
      step(3, 0, 'h10); idle(2); step(2, 0, 'h21); step(0, 0, 0); step(3, 0, 'h33);
      step(2, 0, 'h44, 1); idle(12);
      phase = "R13 auto precharge";
      step(2, 0, 'h408); idle(12);
      step(2, 0, 'h418); idle(2); step(2, 0, 'h20); idle(12);
      step(3, 0, 'h405); idle(10);
      phase = "R14 clock freeze";
      step(2, 0, 'h50); step(0, 0, 0, 0, 1'b1); step(0, 0, 0, 1, 1'b0);
      step(2, 0, 'h77, 2, 1'b0); step(0, 0, 0, 0, 1'b1); step(3, 0, 'h60);
      step(0, 0, 0, 1, 1'b0); step(0, 0, 0, 0, 1'b1); idle(12);
      phase = "R7 full page wrap"; step(1, 0, 'h17); idle(2); step(2, 0, 'h1FE);
      idle(520);
      phase = "R8 stop full page"; step(4, 0, 0); idle(4);
      step(3, 0, 7); idle(5); step(4, 0, 0); idle(3);
      phase = "R8 stop short burst"; step(1, 0, 'h23); idle(2); step(2, 0, 9);
      step(0, 0, 0); step(4, 0, 0); idle(6);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule